// File: doc/BRIEF.md
# Two-Phase Charge-Sharing DAC Switch Sequencer

This block drives the switches of a 10-bit charge-sharing converter. The converter is built from a 32-segment resistor ladder and 32 equal capacitors. Each input code is split into a ladder index and a capacitor count. The index picks a pair of adjacent ladder nodes. The count sets how many capacitors charge to the upper node of that pair; the rest charge to the lower node.

After charging, every capacitor is released from the ladder. The capacitors are then shorted together onto the output node, so the shared charge lands between the two node voltages in 1/32 steps. Because the capacitor count is expanded as a thermometer pattern, the conversion is monotonic.

The sequencer runs from a clock at eight times the conversion rate. Each conversion frame has four phases in a fixed order: charge, gap, share, gap. The gap ticks keep the ladder switches and the share switches from ever closing together. A new code is taken only where a frame begins. A code that arrives at any other time waits until the next frame.

Top module: `pdac_seq`

## Requirements
- R1: The ladder index is code bits [9:5] and the capacitor count is code bits [4:0]. In the charge phase, `tap_lo_o` is one-hot with bit M set, where M is the index; bit k selects ladder node k (k/32 of the reference).
- R2: In the charge phase, `tap_hi_o` is one-hot with bit M set; bit k selects ladder node k+1 ((k+1)/32 of the reference).
- R3: In the charge phase, `cap_hi_o` bit i is 1 exactly when i < N, where N is the count. `cap_lo_o` is its bitwise complement, so no capacitor connects to both nodes.
- R4: In the share phase, every bit of `cap_shr_o` is 1 and all tap and ladder-capacitor switches are 0.
- R5: Frames repeat every 8 clocks. Ticks 0–3 are charge, tick 4 is gap, ticks 5–6 are share and tick 7 is gap. `cap_shr_o` is nonzero only on ticks 5 and 6.
- R6: In both gap ticks all outputs are 0. A ladder switch and a share switch are never on in the same or in adjacent clocks.
- R7: A code presented with `code_valid_i` on the last tick of a frame is used in the next frame. A code presented on any other tick does not change the current frame; it takes effect in the following frame. The code is constant across a frame.
- R8: When several codes arrive before a frame begins, the most recent one is used.
- R9: A frame with no new code since the previous frame start repeats the previous code.
- R10: While `rst_ni` is low all outputs are 0. The first frame after reset uses code 0 unless a code is presented on the first clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sequencer clock, 8x conversion rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| code_i | input | 10 | Conversion code |
| code_valid_i | input | 1 | Code strobe, one clock per code |
| tap_lo_o | output | 32 | One-hot lower ladder node select |
| tap_hi_o | output | 32 | One-hot upper ladder node select |
| cap_hi_o | output | 32 | Per-capacitor switch to upper node |
| cap_lo_o | output | 32 | Per-capacitor switch to lower node |
| cap_shr_o | output | 32 | Per-capacitor switch to shared output |

## Verification
The bench builds the block with its defaults: a 5-bit index, a 5-bit count and a 4/1/2/1 tick frame. These values give the real 32-node, 32-capacitor switch patterns. Among them are the extreme codes 0, 31, 32, 992 and 1023, where the thermometer is empty or one short of full and the index sits at either end of the ladder. The short frame lets the bench place a code strobe on each tick position, including the last tick of a frame, and check every tick of the frames that follow. This covers the latching, overwrite and hold orderings in a few hundred clocks.

// File: rtl/pdac_seq_pkg.sv
package pdac_seq_pkg;
  typedef enum logic [1:0] {
    PH_CHARGE = 2'd0,
    PH_GAP    = 2'd1,
    PH_SHARE  = 2'd2
  } phase_e;
endpackage

// File: rtl/pdac_seq_timer.sv
module pdac_seq_timer
  import pdac_seq_pkg::*;
#(
  parameter int CHG_TICKS = 4,
  parameter int GAP_TICKS = 1,
  parameter int SHR_TICKS = 2
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  output phase_e phase_o,
  output logic   wrap_o
);
  localparam int FRAME  = CHG_TICKS + 2 * GAP_TICKS + SHR_TICKS;
  localparam int TW     = $clog2(FRAME);
  localparam int LAST   = FRAME - 1;
  localparam int GAP1_E = CHG_TICKS + GAP_TICKS;
  localparam int SHR_E  = GAP1_E + SHR_TICKS;

  logic [TW-1:0] tick_q;
  int            tick;

  assign wrap_o = (tick_q == TW'(LAST));
  assign tick   = int'(tick_q);

  // reset parks in the trailing gap so the first edge opens a charge phase
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     tick_q <= TW'(LAST);
    else if (wrap_o) tick_q <= '0;
    else             tick_q <= tick_q + 1'b1;
  end

  always_comb begin
    if (tick < CHG_TICKS)   phase_o = PH_CHARGE;
    else if (tick < GAP1_E) phase_o = PH_GAP;
    else if (tick < SHR_E)  phase_o = PH_SHARE;
    else                    phase_o = PH_GAP;
  end

  AST_CHARGE_AFTER_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> phase_o == PH_CHARGE); // R5

  AST_GAP_INTO_SHARE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == PH_SHARE && $past(phase_o) != PH_SHARE) |-> $past(phase_o) == PH_GAP); // R6
endmodule

// File: rtl/pdac_seq_latch.sv
module pdac_seq_latch #(
  parameter int CODE_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] code_i,
  input  logic              code_valid_i,
  input  logic              load_i,
  output logic [CODE_W-1:0] code_o
);
  logic [CODE_W-1:0] pend_q;
  logic              pend_v_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q   <= '0;
      pend_v_q <= 1'b0;
      code_o   <= '0;
    end else if (load_i) begin
      // a strobe on the boundary tick bypasses the pending slot
      if (code_valid_i)  code_o <= code_i;
      else if (pend_v_q) code_o <= pend_q;
      pend_v_q <= 1'b0;
    end else if (code_valid_i) begin
      pend_q   <= code_i;
      pend_v_q <= 1'b1;
    end
  end

  AST_CODE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(code_o)); // R7

  AST_DIRECT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && code_valid_i) |=> code_o == $past(code_i)); // R7
endmodule

// File: rtl/pdac_seq_decode.sv
module pdac_seq_decode
  import pdac_seq_pkg::*;
#(
  parameter int IDX_W = 5,
  parameter int CNT_W = 5
) (
  input  phase_e                     phase_i,
  input  logic [IDX_W+CNT_W-1:0]     code_i,
  output logic [(1<<IDX_W)-1:0]      tap_lo_o,
  output logic [(1<<IDX_W)-1:0]      tap_hi_o,
  output logic [(1<<CNT_W)-1:0]      cap_hi_o,
  output logic [(1<<CNT_W)-1:0]      cap_lo_o,
  output logic [(1<<CNT_W)-1:0]      cap_shr_o
);
  localparam int CODE_W = IDX_W + CNT_W;
  localparam int NTAP   = 1 << IDX_W;
  localparam int NCAP   = 1 << CNT_W;

  logic [IDX_W-1:0] idx;
  logic [CNT_W-1:0] cnt;
  logic [NTAP-1:0]  tap_sel;
  logic [NCAP-1:0]  therm;
  logic             charge;
  logic             share;

  assign idx    = code_i[CODE_W-1:CNT_W];
  assign cnt    = code_i[CNT_W-1:0];
  assign charge = (phase_i == PH_CHARGE);
  assign share  = (phase_i == PH_SHARE);

  for (genvar k = 0; k < NTAP; k++) begin : g_tap
    assign tap_sel[k] = (idx == IDX_W'(k));
  end

  for (genvar i = 0; i < NCAP; i++) begin : g_therm
    assign therm[i] = (cnt > CNT_W'(i));
  end

  assign tap_lo_o  = charge ? tap_sel : '0;
  assign tap_hi_o  = charge ? tap_sel : '0;
  assign cap_hi_o  = charge ? therm   : '0;
  assign cap_lo_o  = charge ? ~therm  : '0;
  assign cap_shr_o = share  ? '1      : '0;

  always_comb begin
    AST_CAP_EXCL: assert ((cap_hi_o & cap_lo_o) == '0); // R3
  end
endmodule

// File: rtl/pdac_seq.sv
module pdac_seq
  import pdac_seq_pkg::*;
#(
  parameter int IDX_W     = 5,
  parameter int CNT_W     = 5,
  parameter int CHG_TICKS = 4,
  parameter int GAP_TICKS = 1,
  parameter int SHR_TICKS = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [IDX_W+CNT_W-1:0]   code_i,
  input  logic                     code_valid_i,
  output logic [(1<<IDX_W)-1:0]    tap_lo_o,
  output logic [(1<<IDX_W)-1:0]    tap_hi_o,
  output logic [(1<<CNT_W)-1:0]    cap_hi_o,
  output logic [(1<<CNT_W)-1:0]    cap_lo_o,
  output logic [(1<<CNT_W)-1:0]    cap_shr_o
);
  localparam int CODE_W = IDX_W + CNT_W;
  localparam int NCAP   = 1 << CNT_W;

  phase_e            phase;
  logic              wrap;
  logic [CODE_W-1:0] act_code;

  pdac_seq_timer #(
    .CHG_TICKS(CHG_TICKS),
    .GAP_TICKS(GAP_TICKS),
    .SHR_TICKS(SHR_TICKS)
  ) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .phase_o(phase),
    .wrap_o (wrap)
  );

  pdac_seq_latch #(.CODE_W(CODE_W)) u_latch (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .code_i      (code_i),
    .code_valid_i(code_valid_i),
    .load_i      (wrap),
    .code_o      (act_code)
  );

  pdac_seq_decode #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_decode (
    .phase_i  (phase),
    .code_i   (act_code),
    .tap_lo_o (tap_lo_o),
    .tap_hi_o (tap_hi_o),
    .cap_hi_o (cap_hi_o),
    .cap_lo_o (cap_lo_o),
    .cap_shr_o(cap_shr_o)
  );

  logic ladder_on;
  assign ladder_on = (|tap_lo_o) || (|tap_hi_o) || (|cap_hi_o) || (|cap_lo_o);

  AST_NO_OVERLAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ladder_on && (|cap_shr_o))); // R6

  AST_GAP_BEFORE_SHARE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(|cap_shr_o) |-> $past(!ladder_on)); // R6

  AST_GAP_BEFORE_CHARGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ladder_on) |-> $past(cap_shr_o == '0)); // R6

  AST_FULL_CHARGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|tap_lo_o) |-> $countones(cap_hi_o | cap_lo_o) == NCAP); // R3

  AST_TAP_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(tap_lo_o) && $onehot0(tap_hi_o)); // R2
endmodule

// File: tb/tb_pdac_seq.sv
module tb_pdac_seq;
  localparam int CLK_PERIOD = 10;
  localparam int FRAME      = 8;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [9:0]  code_i = '0;
  logic        code_valid_i = 1'b0;
  logic [31:0] tap_lo_o, tap_hi_o, cap_hi_o, cap_lo_o, cap_shr_o;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pdac_seq dut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .code_i      (code_i),
    .code_valid_i(code_valid_i),
    .tap_lo_o    (tap_lo_o),
    .tap_hi_o    (tap_hi_o),
    .cap_hi_o    (cap_hi_o),
    .cap_lo_o    (cap_lo_o),
    .cap_shr_o   (cap_shr_o)
  );

  task automatic chk(input string req, input string tag, input int t,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s (%s) tick=%0d act=%h exp=%h", req, tag, t, act, exp);
    end
  endtask

  // checks one full frame; optional strobes injected after the check of a tick
  task automatic run_frame(input logic [9:0] code, input string tag,
                           input int i1_t, input logic [9:0] i1_c,
                           input int i2_t, input logic [9:0] i2_c);
    logic [31:0] e_tap, e_hi;
    int m, n;
    m = int'(code[9:5]);
    n = int'(code[4:0]);
    e_tap = 32'h1 << m;
    e_hi  = (n == 0) ? 32'h0 : ((32'h1 << n) - 32'h1);
    for (int t = 0; t < FRAME; t++) begin
      @(negedge clk);
      code_valid_i = 1'b0;
      if (t < 4) begin
        chk("R1", tag, t, tap_lo_o, e_tap);
        chk("R2", tag, t, tap_hi_o, e_tap);
        chk("R3", tag, t, cap_hi_o, e_hi);
        chk("R3", tag, t, cap_lo_o, ~e_hi);
        chk("R5", tag, t, cap_shr_o, 32'h0);
      end else if (t == 5 || t == 6) begin
        chk("R4", tag, t, cap_shr_o, 32'hFFFF_FFFF);
        chk("R4", tag, t, tap_lo_o | tap_hi_o | cap_hi_o | cap_lo_o, 32'h0);
      end else begin
        chk("R6", tag, t, tap_lo_o | tap_hi_o | cap_hi_o | cap_lo_o | cap_shr_o, 32'h0);
      end
      if (t == i1_t) begin code_i = i1_c; code_valid_i = 1'b1; end
      if (t == i2_t) begin code_i = i2_c; code_valid_i = 1'b1; end
    end
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    code_valid_i = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R10", "reset", i, tap_lo_o | tap_hi_o | cap_hi_o | cap_lo_o | cap_shr_o, 32'h0);
    end
    rst_ni = 1'b1;
    run_frame(10'd0, "R10 first frame", -1, '0, -1, '0);
  endtask

  // code presented on the last tick of the previous frame
  task automatic t_basic(input logic [9:0] code);
    code_i = code;
    code_valid_i = 1'b1;
    run_frame(code, "R1 boundary load", -1, '0, -1, '0);
  endtask

  task automatic t_midcycle();
    code_i = 10'h155;
    code_valid_i = 1'b1;
    run_frame(10'h155, "R7 midframe ignored", 2, 10'h0CC, -1, '0);
    run_frame(10'h0CC, "R7 pending applied", -1, '0, -1, '0);
  endtask

  task automatic t_overwrite();
    run_frame(10'h0CC, "R8 frame holds", 0, 10'h111, 5, 10'h222);
    run_frame(10'h222, "R8 newest wins", -1, '0, -1, '0);
  endtask

  task automatic t_hold();
    run_frame(10'h222, "R9 repeat", -1, '0, -1, '0);
    run_frame(10'h222, "R9 repeat again", 7, 10'h3FF, -1, '0);
    run_frame(10'h3FF, "R7 last tick load", -1, '0, -1, '0);
  endtask

  initial begin
    t_reset();
    t_basic(10'h2AB);
    t_basic(10'h3FF);
    t_basic(10'h000);
    t_basic(10'h020);
    t_basic(10'h01F);
    t_basic(10'h3E0);
    t_basic(10'h201);
    t_midcycle();
    t_overwrite();
    t_hold();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog act=running exp=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule